// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

This block is a slave on a two-wire serial bus (SMBus-style, standard-mode rate), run from a faster system clock that oversamples both lines. It owns a bank of 23 byte-wide configuration registers. Every access is a block transfer. The master names a starting register index, and the slave then steps through the registers one by one in ascending order.

A write carries the index, then a byte count, then the data bytes. A read sets the index with a write-address phase, then issues a repeated start with the read address. The slave answers with the stored count byte first, followed by the register contents. Two of the registers are fixed by hardware. One returns strap pins that are latched at power-on. The other returns a constant identity value.

Both bus lines are open-drain. The slave sees each line as an input, and it pulls SDA low through an output-enable. It never drives SCL. The whole register image is presented on a flat output bus for use by the surrounding clock logic.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) or 0xD3 (read), i.e. 7-bit address 0x69 plus the direction bit. On any other address it leaves SDA released for the ninth clock, goes idle and ignores the bus until the next start.
- R2: Write transfer: address 0xD2, index M, count N, then data bytes. The slave acks each of these bytes, and data byte k lands in register M+k.
- R3: Read transfer: address 0xD2, index M, repeated start, address 0xD3. The slave sends the count byte last written first, then registers M, M+1, and so on, MSB first. It keeps sending while the master acks, and goes idle after a master not-acknowledge.
- R4: The register index increments after every data byte. A write keeps storing data bytes past the count N until a stop arrives.
- R5: Register 8 always reads 0xF1, and writes to it leave it unchanged.
- R6: Register 5 reads {2'b00, strap_i[5:0]}, and writes to it are ignored.
- R7: After reset the registers hold the following values. Registers 0–3, 7 and 10 hold 0xFF. Register 6 holds 0x0B, register 9 holds 0xB1, register 11 holds 0x3F, register 18 holds 0x44 and register 19 holds 0x40. All other writable registers hold 0x00.
- R8: An index above 22 is still acked. Write data sent to such an index is discarded, and a read from it returns 0x00.
- R9: A start or stop that arrives partway through a byte aborts the transfer. Bytes already completed stay stored.
- R10: The slave acks by holding SDA low for the whole ninth clock. It changes SDA only while SCL is low.
- R11: The slave ignores a pulse on SCL or SDA that is shorter than FILT_LEN system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 6 | Latched strap levels shown in register 5 |
| regs_o | output | NREG*8 | Register image, register i at bits [8i+7:8i] |

## Verification
The assertions rely on two properties of a well-behaved master. First, it changes SDA only while SCL is low, except for start and stop. Second, it never issues a stop while the slave is driving an acknowledge or a data bit. The stimulus meets both conditions with a four-quarter bit timing: SDA changes at least one quarter-bit away from every SCL edge, and each quarter-bit lasts far longer than the synchronizer and filter delay. The only intentional breaks in that timing are a short SCL glitch, which the filter must swallow, and a stop placed partway through a byte. That stop is issued only while the slave is receiving.

// File: rtl/cfg_smb_pkg.sv
package cfg_smb_pkg;
  localparam int unsigned NUM_REGS  = 23;
  localparam int unsigned STRAP_W   = 6;
  localparam int unsigned STRAP_IDX = 5;
  localparam int unsigned ID_IDX    = 8;
  localparam logic [7:0]  ID_VALUE  = 8'hF1;
  localparam logic [6:0]  DEV_ADDR  = 7'h69;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK} smb_state_e;
  typedef enum logic [1:0] {PH_ADDR, PH_INDEX, PH_COUNT, PH_DATA} smb_phase_e;

  function automatic logic [7:0] reg_default(int unsigned i);
    case (i)
      0, 1, 2, 3, 7, 10: return 8'hFF;
      6:                 return 8'h0B;
      9:                 return 8'hB1;
      11:                return 8'h3F;
      18:                return 8'h44;
      19:                return 8'h40;
      default:           return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned SYNC_LEN = 2,
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SYNC_LEN-1:0] sync_q;
  logic [CW-1:0]       cnt_q;
  logic                synced;

  assign synced = sync_q[SYNC_LEN-1];

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], line_i};
      if (synced == line_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        line_o <= synced;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R11
  filt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> $past(cnt_q) == CW'(FILT_LEN - 1));
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import cfg_smb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_idx_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_idx_o,
  input  logic [7:0] rd_data_i
);
  smb_state_e state_q;
  smb_phase_e phase_q;
  logic       scl_d_q, sda_d_q, rd_mode_q, cnt_pend_q, mack_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, idx_q, cnt_q;
  logic       scl_rise, scl_fall, start_evt, stop_evt, byte_done;

  assign scl_rise  = scl_i & ~scl_d_q;
  assign scl_fall  = ~scl_i & scl_d_q;
  assign start_evt = scl_i & scl_d_q & sda_d_q & ~sda_i;
  assign stop_evt  = scl_i & scl_d_q & ~sda_d_q & sda_i;
  assign byte_done = (state_q == ST_RX) && scl_fall && (bit_q == 4'd8);

  assign wr_en_o   = byte_done && (phase_q == PH_DATA) && !rd_mode_q;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = sh_q;
  assign rd_idx_o  = idx_q;
  assign sda_oe_o  = (state_q == ST_ACK) || ((state_q == ST_TX) && !sh_q[7]);

  function automatic logic [7:0] idx_next(logic [7:0] i);
    return (i == 8'hFF) ? i : i + 8'd1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_ADDR;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
      rd_mode_q  <= 1'b0;
      cnt_pend_q <= 1'b0;
      mack_q     <= 1'b0;
      bit_q      <= '0;
      sh_q       <= '0;
      idx_q      <= '0;
      cnt_q      <= '0;
    end else begin
      scl_d_q <= scl_i;
      sda_d_q <= sda_i;
      if (stop_evt) begin
        state_q <= ST_IDLE;
      end else if (start_evt) begin
        state_q <= ST_RX;
        phase_q <= PH_ADDR;
        bit_q   <= '0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise && bit_q != 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_i};
              bit_q <= bit_q + 4'd1;
            end else if (byte_done) begin
              bit_q   <= '0;
              state_q <= ST_ACK;
              case (phase_q)
                PH_ADDR: begin
                  if (sh_q[7:1] == DEV_ADDR) begin
                    rd_mode_q  <= sh_q[0];
                    cnt_pend_q <= 1'b1;
                    phase_q    <= sh_q[0] ? PH_DATA : PH_INDEX;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                PH_INDEX: begin
                  idx_q   <= sh_q;
                  phase_q <= PH_COUNT;
                end
                PH_COUNT: begin
                  cnt_q   <= sh_q;
                  phase_q <= PH_DATA;
                end
                default: idx_q <= idx_next(idx_q);
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_q <= '0;
              if (rd_mode_q) begin
                state_q    <= ST_TX;
                cnt_pend_q <= 1'b0;
                if (cnt_pend_q) begin
                  sh_q <= cnt_q;
                end else begin
                  sh_q  <= rd_data_i;
                  idx_q <= idx_next(idx_q);
                end
              end else begin
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_q == 4'd7) begin
                state_q <= ST_TXACK;
                bit_q   <= '0;
              end else begin
                sh_q  <= {sh_q[6:0], 1'b0};
                bit_q <= bit_q + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_i;
            end else if (scl_fall) begin
              if (mack_q) begin
                state_q <= ST_TX;
                sh_q    <= rd_data_i;
                idx_q   <= idx_next(idx_q);
                bit_q   <= '0;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_oe_o));

  // R1
  ack_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACK && $past(state_q) != ST_ACK) |-> ($past(state_q) == ST_RX && $past(scl_fall)));

  // R3
  tx_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX && $past(state_q) != ST_TX) |-> ($past(state_q) == ST_ACK || $past(state_q) == ST_TXACK));

  // R9
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_evt) |-> state_q == ST_IDLE);
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_smb_pkg::*;
#(
  parameter int unsigned NREG = NUM_REGS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [7:0]           wr_idx_i,
  input  logic [7:0]           wr_data_i,
  input  logic [7:0]           rd_idx_i,
  output logic [7:0]           rd_data_o,
  input  logic [STRAP_W-1:0]   strap_i,
  output logic [NREG*8-1:0]    regs_o
);
  localparam int unsigned IW    = $clog2(NREG);
  localparam int unsigned DEPTH = 1 << IW;

  logic [7:0] bytes [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    if (g >= NREG) begin : g_pad
      assign bytes[g] = 8'h00;
    end else if (g == STRAP_IDX) begin : g_strap
      assign bytes[g] = {{(8 - STRAP_W){1'b0}}, strap_i};
    end else if (g == ID_IDX) begin : g_id
      assign bytes[g] = ID_VALUE;
    end else begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                q <= reg_default(g);
        else if (wr_en_i && wr_idx_i == 8'(g))      q <= wr_data_i;
      end
      assign bytes[g] = q;
    end
    if (g < NREG) begin : g_out
      assign regs_o[g*8 +: 8] = bytes[g];
    end
  end

  assign rd_data_o = (rd_idx_i < 8'(NREG)) ? bytes[rd_idx_i[IW-1:0]] : 8'h00;

  // R2
  wr_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i < 8'(NREG) && wr_idx_i != 8'(ID_IDX) && wr_idx_i != 8'(STRAP_IDX))
    |=> bytes[$past(wr_idx_i[IW-1:0])] == $past(wr_data_i));

  // R8
  oor_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i >= 8'(NREG) && $stable(strap_i)) |=> $stable(regs_o));
endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave
  import cfg_smb_pkg::*;
#(
  parameter int unsigned SYNC_LEN = 2,
  parameter int unsigned FILT_LEN = 4,
  parameter int unsigned NREG     = NUM_REGS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [NREG*8-1:0]  regs_o
);
  logic       scl_f, sda_f, wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

  smb_line_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .line_o(scl_f));

  smb_line_filter #(.SYNC_LEN(SYNC_LEN), .FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .line_o(sda_f));

  smb_proto_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
    .sda_oe_o(sda_oe_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .rd_idx_o(rd_idx), .rd_data_i(rd_data));

  cfg_reg_bank #(.NREG(NREG)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .strap_i(strap_i), .regs_o(regs_o));
endmodule

// File: tb/cfg_smbus_slave_test.sv
module cfg_smbus_slave_test;
  localparam int Q     = 16;     // system clocks per quarter bit
  localparam int NREG  = 23;
  localparam logic [5:0] STRAP = 6'h2D;

  // {index, write data, expected readback}
  localparam logic [23:0] VEC [6] = '{
    {8'd4,  8'h5A, 8'h5A},   // R2
    {8'd8,  8'h00, 8'hF1},   // R5
    {8'd5,  8'hFF, 8'h2D},   // R6
    {8'd22, 8'hA5, 8'hA5},   // R2 top register
    {8'd30, 8'h77, 8'h00},   // R8
    {8'd0,  8'h12, 8'h12}    // R2
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe_o, sda_line;
  logic [NREG*8-1:0] regs_o;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;
  assign sda_line = m_sda & ~sda_oe_o;

  cfg_smbus_slave uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .strap_i(STRAP), .regs_o(regs_o));

  function automatic logic [7:0] exp_default(int i);
    case (i)
      0, 1, 2, 3, 7, 10: return 8'hFF;
      5:  return {2'b00, STRAP};
      6:  return 8'h0B;
      8:  return 8'hF1;
      9:  return 8'hB1;
      11: return 8'h3F;
      18: return 8'h44;
      19: return 8'h40;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic qw(input int n);
    repeat (n * Q) @(negedge clk_i);
  endtask

  task automatic start_cond();
    m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1); m_sda = 1'b0; qw(1); m_scl = 1'b0; qw(1);
  endtask

  task automatic stop_cond();
    m_sda = 1'b0; qw(1); m_scl = 1'b1; qw(1); m_sda = 1'b1; qw(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, input bit glitch);
    for (int i = 0; i < nbits; i++) begin
      m_sda = b[7-i];
      if (glitch && i == 0) begin
        repeat (4) @(negedge clk_i);
        m_scl = 1'b1;
        repeat (2) @(negedge clk_i);
        m_scl = 1'b0;
        repeat (Q - 6) @(negedge clk_i);
      end else begin
        qw(1);
      end
      m_scl = 1'b1; qw(2); m_scl = 1'b0; qw(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output logic ack);
    send_bits(b, 8, glitch);
    m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1);
    ack = ~sda_line;
    qw(1); m_scl = 1'b0; qw(1);
  endtask

  task automatic recv_byte(input bit ack_it, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qw(1); m_scl = 1'b1; qw(1); b = {b[6:0], sda_line}; qw(1); m_scl = 1'b0; qw(1);
    end
    m_sda = ~ack_it; qw(1); m_scl = 1'b1; qw(2); m_scl = 1'b0; qw(1); m_sda = 1'b1;
  endtask

  task automatic write_bytes(input logic [7:0] idx, input logic [7:0] cnt, input int nb,
                             input logic [23:0] d, input bit glitch, input string req);
    logic a;
    start_cond();
    send_byte(8'hD2, 1'b0, a); check8({req, " addr ack"}, 8'(a), 8'd1);
    send_byte(idx, 1'b0, a);   check8({req, " index ack"}, 8'(a), 8'd1);
    send_byte(cnt, 1'b0, a);   check8({req, " count ack"}, 8'(a), 8'd1);
    for (int k = 0; k < nb; k++) begin
      send_byte(d[23-8*k -: 8], glitch && k == 0, a);
      check8({req, " data ack"}, 8'(a), 8'd1);
    end
    stop_cond();
  endtask

  task automatic read_bytes(input logic [7:0] idx, input int n, output logic [7:0] cnt,
                            output logic [23:0] d, input string req);
    logic a;
    logic [7:0] b;
    d = '0;
    start_cond();
    send_byte(8'hD2, 1'b0, a); check8({req, " R1 wr addr ack"}, 8'(a), 8'd1);
    send_byte(idx, 1'b0, a);   check8({req, " index ack"}, 8'(a), 8'd1);
    start_cond();
    send_byte(8'hD3, 1'b0, a); check8({req, " R1 rd addr ack"}, 8'(a), 8'd1);
    recv_byte(1'b1, cnt);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      d[23-8*k -: 8] = b;
    end
    stop_cond();
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  cnt;
    logic [23:0] d;
    logic        a;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    // R7 reset image, R10 released while idle
    for (int i = 0; i < NREG; i++) check8("R7 reset value", regs_o[i*8 +: 8], exp_default(i));
    check8("R10 idle release", 8'(sda_oe_o), 8'd0);

    // table walk: write one byte, read it back with count 1
    foreach (VEC[v]) begin
      write_bytes(VEC[v][23:16], 8'd1, 1, {VEC[v][15:8], 16'h0}, 1'b0, "R2 vec");
      read_bytes(VEC[v][23:16], 1, cnt, d, "R3 vec");
      check8("R3 count first", cnt, 8'd1);
      check8("R2/R5/R6/R8 readback", d[23:16], VEC[v][7:0]);
    end

    // R3 multi-byte read of reset values, ascending
    read_bytes(8'd6, 3, cnt, d, "R3 multi");
    check8("R3 count", cnt, 8'd1);
    check8("R3 byte6", d[23:16], 8'h0B);
    check8("R3 byte7", d[15:8], 8'hFF);
    check8("R3 byte8", d[7:0], 8'hF1);

    // R4 data beyond count keeps loading
    write_bytes(8'd15, 8'd1, 2, 24'hC3_5E00, 1'b0, "R4");
    check8("R4 reg15", regs_o[15*8 +: 8], 8'hC3);
    check8("R4 reg16", regs_o[16*8 +: 8], 8'h5E);

    // R8 run across the top of the bank
    write_bytes(8'd21, 8'd3, 3, 24'h11_2233, 1'b0, "R8");
    check8("R8 reg21", regs_o[21*8 +: 8], 8'h11);
    check8("R8 reg22", regs_o[22*8 +: 8], 8'h22);
    read_bytes(8'd22, 2, cnt, d, "R8 read");
    check8("R8 count", cnt, 8'd3);
    check8("R8 in range", d[23:16], 8'h22);
    check8("R8 past end", d[15:8], 8'h00);

    // R1 wrong address: no ack, rest of transfer ignored
    start_cond();
    send_byte(8'hA4, 1'b0, a); check8("R1 mismatch no ack", 8'(a), 8'd0);
    send_byte(8'd12, 1'b0, a); check8("R1 idle after mismatch", 8'(a), 8'd0);
    send_byte(8'h99, 1'b0, a);
    stop_cond();
    check8("R1 reg12 untouched", regs_o[12*8 +: 8], 8'h00);

    // R9 stop partway through second data byte
    start_cond();
    send_byte(8'hD2, 1'b0, a);
    send_byte(8'd12, 1'b0, a);
    send_byte(8'd2, 1'b0, a);
    send_byte(8'h3C, 1'b0, a); check8("R9 first byte ack", 8'(a), 8'd1);
    send_bits(8'hA0, 4, 1'b0);
    stop_cond();
    check8("R9 completed byte kept", regs_o[12*8 +: 8], 8'h3C);
    check8("R9 partial byte dropped", regs_o[13*8 +: 8], 8'h00);
    check8("R9 bus released", 8'(sda_oe_o), 8'd0);

    // R11 short SCL glitch inside a data byte
    write_bytes(8'd20, 8'd1, 1, 24'h96_0000, 1'b1, "R11");
    check8("R11 glitch ignored", regs_o[20*8 +: 8], 8'h96);

    // R5 / R6 at the register image after writes
    check8("R5 id kept", regs_o[8*8 +: 8], 8'hF1);
    check8("R6 strap kept", regs_o[5*8 +: 8], {2'b00, STRAP});

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule